// File: doc/BRIEF.md
# Segmented Bus Repeater Row

This block is a row of programmable switches that sit on the boundaries between neighbouring logic blocks. Four segment ends meet at each switch. The west block supplies a local segment and an express segment, and the east block supplies a local segment and an express segment. A stored 5-bit code chooses which of these ends are driven and where each one takes its value from. Every connection runs one way only. It goes from an input segment on one side to an output segment on the other side. An end that is not driven has its drive enable low and its value held at 0.

Only 28 connection patterns are legal. For each of the four destination ends, a pattern chooses one of three sources: none, the far-side local segment, or the far-side express segment. A pattern is legal when it makes one or two connections and no two segments drive each other. The legal set therefore covers several cases:
- the crossover (local to far express together with express to far local);
- fan-out of one segment to both far segments;
- chains such as local to far local with far express back to local;
- local to the far express segment in both directions.

Code 0 and the codes above 28 connect nothing. A pass-gate bit for each switch can release all four outputs without losing the stored code. Each switch has its own load strobe for the code and its own load strobe for the pass bit. The code bus and the pass value are shared along the row. The segment datapath is purely combinational.

Top module: `seg_repeater_row`

## Requirements
- R1: While reset is asserted and after it is released, every switch holds code 0 and pass bit 0, so all drive enables are low.
- R2: Code 0 and codes 29, 30 and 31 leave all four drive enables of that switch low.
- R3: A source value s is assigned to each destination: 0 means none, 1 means the far-side local segment, 2 means the far-side express segment. Codes 1 to 28 select the legal patterns in ascending order of n = s_WL + 3·s_WX + 9·s_EL + 27·s_EX. A pattern is legal when it has one or two nonzero entries and no two segments drive each other. With the pass bit set, an output's enable is high exactly when its entry is nonzero.
- R4: An enabled output carries the current value of its selected far-side input in the same cycle. West outputs take their source from the east inputs, and east outputs take their source from the west inputs.
- R5: No driven pattern enables more than two outputs, and no two segments of one switch drive each other.
- R6: With the pass bit at 0, all four enables of that switch are low. Setting the bit back to 1 restores the stored pattern unchanged.
- R7: A code is stored at the rising clock edge at which that switch's load strobe is high, and takes effect from that edge. Without the strobe, changes on the code bus have no effect.
- R8: A strobe for one switch leaves every other switch's code and outputs unchanged.
- R9: A released output drives value 0.
- R10: Each output has at most one source enabled at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | NUM_RPT | Per-switch strobe to store cfg_code |
| cfg_code | input | 5 | Connection code shared by the row |
| pass_load | input | NUM_RPT | Per-switch strobe to store pass_val |
| pass_val | input | 1 | Pass-gate value shared by the row |
| wloc_in | input | NUM_RPT | West local segment arriving at each switch |
| wexp_in | input | NUM_RPT | West express segment arriving at each switch |
| eloc_in | input | NUM_RPT | East local segment arriving at each switch |
| eexp_in | input | NUM_RPT | East express segment arriving at each switch |
| wloc_out | output | NUM_RPT | Value driven onto the west local segment |
| wexp_out | output | NUM_RPT | Value driven onto the west express segment |
| eloc_out | output | NUM_RPT | Value driven onto the east local segment |
| eexp_out | output | NUM_RPT | Value driven onto the east express segment |
| wloc_oe | output | NUM_RPT | Drive enable of the west local output |
| wexp_oe | output | NUM_RPT | Drive enable of the west express output |
| eloc_oe | output | NUM_RPT | Drive enable of the east local output |
| eexp_oe | output | NUM_RPT | Drive enable of the east express output |

## Verification
A strobe stores the code or the pass bit at one rising edge, and the outputs reflect the new value from that edge onward. The bench therefore drives strobes at the falling edge and checks after the following falling edge. Segment inputs reach the outputs with no register in the path. The bench changes them away from the clock edge and samples one nanosecond later within the same cycle. For every code it sweeps all sixteen combinations of the four inputs. It compares the outputs against a pattern table that it builds from the legality rule using its own nested enumeration.

// File: rtl/seg_rpt_pkg.sv
package seg_rpt_pkg;
  localparam int CODE_W  = 5;
  localparam int NUM_END = 4;   // destination order: 0 WL, 1 WX, 2 EL, 3 EX
  localparam int NUM_COMBO = 81; // 3 ** NUM_END
  localparam int NUM_LEGAL = 28;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_LOCAL = 2'd1,
    SRC_EXPR  = 2'd2
  } src_e;

  typedef logic [NUM_END-1:0][1:0] route_t;

  // base-3 digit k of n
  function automatic logic [1:0] digit3(int unsigned n, int unsigned k);
    int unsigned div;
    int unsigned tmp;
    div = 1;
    for (int unsigned i = 0; i < k; i++) div = div * 3;
    tmp = (n / div) % 3;
    return tmp[1:0];
  endfunction

  function automatic route_t combo_route(int unsigned n);
    route_t r;
    for (int unsigned k = 0; k < NUM_END; k++) r[k] = digit3(n, k);
    return r;
  endfunction

  // one or two connections, no pair of segments feeding each other
  function automatic logic route_legal(route_t r);
    int unsigned cnt;
    logic loop_hit;
    cnt = 0;
    for (int k = 0; k < NUM_END; k++) if (r[k] != SRC_NONE) cnt++;
    loop_hit = (r[0] == SRC_LOCAL && r[2] == SRC_LOCAL) ||
               (r[0] == SRC_EXPR  && r[3] == SRC_LOCAL) ||
               (r[1] == SRC_LOCAL && r[2] == SRC_EXPR)  ||
               (r[1] == SRC_EXPR  && r[3] == SRC_EXPR);
    return (cnt >= 1) && (cnt <= 2) && !loop_hit;
  endfunction

  // k-th legal pattern for code k, nothing for 0 and codes past the table
  function automatic route_t code_route(logic [CODE_W-1:0] code);
    route_t res;
    route_t cand;
    logic [CODE_W:0] seen;
    res  = '0;
    seen = '0;
    for (int unsigned n = 0; n < NUM_COMBO; n++) begin
      cand = combo_route(n);
      if (route_legal(cand)) begin
        seen = seen + 1'b1;
        if (seen == {1'b0, code}) res = cand;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/seg_rpt_cfg.sv
module seg_rpt_cfg
  import seg_rpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_load,
  input  logic [CODE_W-1:0] code_in,
  input  logic              pass_load,
  input  logic              pass_in,
  output logic [CODE_W-1:0] code_q,
  output logic              pass_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      pass_q <= 1'b0;
    end else begin
      if (code_load) code_q <= code_in;
      if (pass_load) pass_q <= pass_in;
    end
  end
endmodule

// File: rtl/seg_rpt_decode.sv
module seg_rpt_decode
  import seg_rpt_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output route_t            route
);
  always_comb route = code_route(code);
endmodule

// File: rtl/seg_rpt_drive.sv
module seg_rpt_drive
  import seg_rpt_pkg::*;
(
  input  logic               pass_on,
  input  route_t             route,
  input  logic [NUM_END-1:0] seg_in,
  output logic [NUM_END-1:0] seg_out,
  output logic [NUM_END-1:0] seg_oe,
  output logic [NUM_END-1:0] hit_local,
  output logic [NUM_END-1:0] hit_expr
);
  for (genvar d = 0; d < NUM_END; d++) begin : g_end
    // far side: west ends (0,1) read east (2,3), east ends read west
    localparam int FAR_LOC = (d < 2) ? 2 : 0;
    localparam int FAR_EXP = FAR_LOC + 1;
    assign hit_local[d] = pass_on && (route[d] == SRC_LOCAL);
    assign hit_expr[d]  = pass_on && (route[d] == SRC_EXPR);
    assign seg_oe[d]    = hit_local[d] | hit_expr[d];
    assign seg_out[d]   = (hit_local[d] & seg_in[FAR_LOC]) |
                          (hit_expr[d]  & seg_in[FAR_EXP]);
  end
endmodule

// File: rtl/seg_repeater_row.sv
module seg_repeater_row
  import seg_rpt_pkg::*;
#(
  parameter int NUM_RPT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_RPT-1:0] cfg_load,
  input  logic [4:0]         cfg_code,
  input  logic [NUM_RPT-1:0] pass_load,
  input  logic               pass_val,
  input  logic [NUM_RPT-1:0] wloc_in,
  input  logic [NUM_RPT-1:0] wexp_in,
  input  logic [NUM_RPT-1:0] eloc_in,
  input  logic [NUM_RPT-1:0] eexp_in,
  output logic [NUM_RPT-1:0] wloc_out,
  output logic [NUM_RPT-1:0] wexp_out,
  output logic [NUM_RPT-1:0] eloc_out,
  output logic [NUM_RPT-1:0] eexp_out,
  output logic [NUM_RPT-1:0] wloc_oe,
  output logic [NUM_RPT-1:0] wexp_oe,
  output logic [NUM_RPT-1:0] eloc_oe,
  output logic [NUM_RPT-1:0] eexp_oe
);
  // named internal state for the checker
  logic [NUM_RPT-1:0][CODE_W-1:0]  code_q_all;
  logic [NUM_RPT-1:0]              pass_q_all;
  logic [NUM_RPT-1:0][NUM_END-1:0] hit_local_all;
  logic [NUM_RPT-1:0][NUM_END-1:0] hit_expr_all;
  logic [NUM_RPT-1:0][NUM_END-1:0] oe_all;
  logic [NUM_RPT-1:0][NUM_END-1:0] out_all;

  for (genvar i = 0; i < NUM_RPT; i++) begin : g_rpt
    route_t             route;
    logic [NUM_END-1:0] seg_in;

    assign seg_in = {eexp_in[i], eloc_in[i], wexp_in[i], wloc_in[i]};

    seg_rpt_cfg u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .code_load (cfg_load[i]),
      .code_in   (cfg_code),
      .pass_load (pass_load[i]),
      .pass_in   (pass_val),
      .code_q    (code_q_all[i]),
      .pass_q    (pass_q_all[i])
    );

    seg_rpt_decode u_dec (
      .code  (code_q_all[i]),
      .route (route)
    );

    seg_rpt_drive u_drv (
      .pass_on   (pass_q_all[i]),
      .route     (route),
      .seg_in    (seg_in),
      .seg_out   (out_all[i]),
      .seg_oe    (oe_all[i]),
      .hit_local (hit_local_all[i]),
      .hit_expr  (hit_expr_all[i])
    );

    assign wloc_out[i] = out_all[i][0];
    assign wexp_out[i] = out_all[i][1];
    assign eloc_out[i] = out_all[i][2];
    assign eexp_out[i] = out_all[i][3];
    assign wloc_oe[i]  = oe_all[i][0];
    assign wexp_oe[i]  = oe_all[i][1];
    assign eloc_oe[i]  = oe_all[i][2];
    assign eexp_oe[i]  = oe_all[i][3];
  end
endmodule

// File: rtl/seg_repeater_row_chk.sv
module seg_repeater_row_chk
  import seg_rpt_pkg::*;
#(
  parameter int NUM_RPT = 4
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [NUM_RPT-1:0]                cfg_load,
  input logic [NUM_RPT-1:0][CODE_W-1:0]    code_q_all,
  input logic [NUM_RPT-1:0]                pass_q_all,
  input logic [NUM_RPT-1:0][NUM_END-1:0]   hit_local_all,
  input logic [NUM_RPT-1:0][NUM_END-1:0]   hit_expr_all,
  input logic [NUM_RPT-1:0][NUM_END-1:0]   oe_all,
  input logic [NUM_RPT-1:0][NUM_END-1:0]   out_all
);
  for (genvar i = 0; i < NUM_RPT; i++) begin : g_rpt
    for (genvar d = 0; d < NUM_END; d++) begin : g_end
      // R10: a single source per output
      p_one_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_local_all[i][d], hit_expr_all[i][d]}));
      // R9: released outputs drive 0
      p_released_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_all[i][d] |-> !out_all[i][d]);
    end

    // R6: pass gate off silences the switch
    p_pass_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !pass_q_all[i] |-> (oe_all[i] == '0));

    // R2: unused codes connect nothing
    p_unused_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (code_q_all[i] == '0 || code_q_all[i] > CODE_W'(NUM_LEGAL)) |-> (oe_all[i] == '0));

    // R7: no strobe, no change of the stored code
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_load[i] |=> $stable(code_q_all[i]));

    // R5: at most two outputs driven
    p_max_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(oe_all[i]) <= 2);

    // R5: no two segments feed each other
    p_no_loop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !((hit_local_all[i][0] && hit_local_all[i][2]) ||
        (hit_expr_all[i][0]  && hit_local_all[i][3]) ||
        (hit_local_all[i][1] && hit_expr_all[i][2])  ||
        (hit_expr_all[i][1]  && hit_expr_all[i][3])));
  end
endmodule

bind seg_repeater_row seg_repeater_row_chk #(.NUM_RPT(NUM_RPT)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_load      (cfg_load),
  .code_q_all    (code_q_all),
  .pass_q_all    (pass_q_all),
  .hit_local_all (hit_local_all),
  .hit_expr_all  (hit_expr_all),
  .oe_all        (oe_all),
  .out_all       (out_all)
);

// File: tb/seg_repeater_row_tb_top.sv
module seg_repeater_row_tb_top;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] cfg_load = '0;
  logic [4:0]   cfg_code = '0;
  logic [N-1:0] pass_load = '0;
  logic         pass_val = 1'b0;
  logic [N-1:0] wloc_in = '0, wexp_in = '0, eloc_in = '0, eexp_in = '0;
  logic [N-1:0] wloc_out, wexp_out, eloc_out, eexp_out;
  logic [N-1:0] wloc_oe, wexp_oe, eloc_oe, eexp_oe;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  int tbl [32][4];
  int mcode [N];
  bit mpass [N];

  always #4 clk = ~clk;

  seg_repeater_row #(.NUM_RPT(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_code(cfg_code),
    .pass_load(pass_load), .pass_val(pass_val),
    .wloc_in(wloc_in), .wexp_in(wexp_in), .eloc_in(eloc_in), .eexp_in(eexp_in),
    .wloc_out(wloc_out), .wexp_out(wexp_out), .eloc_out(eloc_out), .eexp_out(eexp_out),
    .wloc_oe(wloc_oe), .wexp_oe(wexp_oe), .eloc_oe(eloc_oe), .eexp_oe(eexp_oe)
  );

  // source segment of destination d for entry v (v 1 local, 2 express)
  function automatic int src_seg(int d, int v);
    return (d < 2) ? (1 + v) : (v - 1);
  endfunction

  // R3 pattern table, built by nested enumeration from the legality rule
  task automatic build_table();
    int code = 0;
    int e [4];
    for (int c = 0; c < 32; c++) for (int d = 0; d < 4; d++) tbl[c][d] = 0;
    for (int x3 = 0; x3 < 3; x3++)
      for (int x2 = 0; x2 < 3; x2++)
        for (int x1 = 0; x1 < 3; x1++)
          for (int x0 = 0; x0 < 3; x0++) begin
            int nconn = 0;
            bit loop_found = 1'b0;
            e[0] = x0; e[1] = x1; e[2] = x2; e[3] = x3;
            for (int d = 0; d < 4; d++) if (e[d] != 0) nconn++;
            for (int a = 0; a < 2; a++)
              for (int b = 2; b < 4; b++)
                if (e[a] != 0 && e[b] != 0 &&
                    src_seg(a, e[a]) == b && src_seg(b, e[b]) == a)
                  loop_found = 1'b1;
            if (nconn >= 1 && nconn <= 2 && !loop_found) begin
              code++;
              for (int d = 0; d < 4; d++) tbl[code][d] = e[d];
            end
          end
    n_checks++;
    if (code != 28) begin
      n_fail++;
      $display("FAIL R3 bench table size act %0d exp 28", code);
    end
  endtask

  task automatic set_inputs(int pat);
    for (int r = 0; r < N; r++) begin
      logic [3:0] v;
      v = 4'(pat) ^ 4'(r * 5);
      wloc_in[r] = v[0]; wexp_in[r] = v[1]; eloc_in[r] = v[2]; eexp_in[r] = v[3];
    end
  endtask

  task automatic check_all(string oe_tag);
    for (int r = 0; r < N; r++) begin
      logic [3:0] ins, act_oe, act_out;
      ins     = {eexp_in[r], eloc_in[r], wexp_in[r], wloc_in[r]};
      act_oe  = {eexp_oe[r], eloc_oe[r], wexp_oe[r], wloc_oe[r]};
      act_out = {eexp_out[r], eloc_out[r], wexp_out[r], wloc_out[r]};
      for (int d = 0; d < 4; d++) begin
        int  v;
        bit  eo, ev;
        v  = mpass[r] ? tbl[mcode[r]][d] : 0;
        eo = (v != 0);
        ev = eo ? ins[src_seg(d, v)] : 1'b0;
        n_checks++;
        if (act_oe[d] !== eo) begin
          n_fail++;
          $display("FAIL %s rep %0d code %0d end %0d oe act %b exp %b",
                   oe_tag, r, mcode[r], d, act_oe[d], eo);
        end
        // R4 drives from selected source; R10: far local and far express differ in
        // half the sweep, so a second enabled source would show up here
        n_checks++;
        if (act_out[d] !== ev) begin
          n_fail++;
          $display("FAIL %s rep %0d code %0d end %0d out act %b exp %b",
                   eo ? "R4" : "R9", r, mcode[r], d, act_out[d], ev);
        end
      end
    end
  endtask

  task automatic sweep(string oe_tag);
    for (int p = 0; p < 16; p++) begin
      set_inputs(p);
      #1;
      check_all(oe_tag);
    end
  endtask

  task automatic load_code(int r, int code);
    @(negedge clk);
    cfg_load = '0; cfg_load[r] = 1'b1; cfg_code = 5'(code);
    @(negedge clk);
    cfg_load = '0;
    mcode[r] = code;
  endtask

  task automatic load_pass(int r, bit v);
    @(negedge clk);
    pass_load = '0; pass_load[r] = 1'b1; pass_val = v;
    @(negedge clk);
    pass_load = '0;
    mpass[r] = v;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired act running exp done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    build_table();
    for (int r = 0; r < N; r++) begin mcode[r] = 0; mpass[r] = 1'b0; end
    // R1: reset state, during and after reset
    repeat (2) @(negedge clk);
    sweep("R1");
    rst_n = 1'b1;
    @(negedge clk);
    sweep("R1");

    for (int r = 0; r < N; r++) load_pass(r, 1'b1);
    sweep("R2");

    // R2, R3, R4, R8: full code sweep on switch 0, others stay at code 0
    for (int c = 0; c < 32; c++) begin
      load_code(0, c);
      sweep((c == 0 || c > 28) ? "R2" : "R3");
    end
    // R3 on the last switch of the row
    for (int c = 1; c <= 28; c++) begin
      load_code(N - 1, c);
      sweep("R3");
    end

    // R7: code bus moves without a strobe
    load_code(0, 5);
    @(negedge clk);
    cfg_code = 5'd17;
    repeat (3) @(negedge clk);
    sweep("R7");

    // R8: strobe on switch 1 only
    load_code(1, 9);
    sweep("R8");

    // R6: pass gate off then on
    load_pass(0, 1'b0);
    sweep("R6");
    load_pass(0, 1'b1);
    sweep("R6");

    // R1: reset in mid-run clears every switch
    @(negedge clk);
    rst_n = 1'b0;
    for (int r = 0; r < N; r++) begin mcode[r] = 0; mpass[r] = 1'b0; end
    #1;
    sweep("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    sweep("R1");

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule